// File: doc/BRIEF.md
# DMA Channel Register File with Byte-Pointer Access

This block holds the programming state of two DMA channels: a 32-bit requester address, a 32-bit target address and a 24-bit byte count for each. A host reaches these values one byte at a time over an 8-bit bus. The full values are always driven in parallel to a DMA transfer engine. The engine itself is outside this block.

Several pairs of bytes share a single host address. A one-bit byte pointer chooses which byte of the pair an access reaches. After every access to such a shared address the pointer flips, so two back-to-back accesses reach the low byte and then the high byte. The upper bytes of the target addresses and of the byte counts have addresses of their own and do not use the pointer. A write to a clear-command address returns the pointer to zero, whatever data is written.

Each access is counted on the rising edge of its strobe. A strobe held high for many cycles is still a single access. Write data appears on the parallel outputs the cycle after the write strobe rises. Read data is registered one cycle after the read strobe rises, and it stays until the next read.

Top module: `dma_chreg_file`

## Requirements
- R1: A synchronous active-high reset clears every channel register, the byte pointer and the read data output to zero.
- R2: Shared addresses use the pointer to select the byte. Pointer 0 selects the lower byte of the pair and pointer 1 the upper byte. The addresses are: F010h requester bytes 0/1 of channel 0, F011h requester bytes 2/3 of channel 0, F000h target bytes 0/1 of channel 0, F001h count bytes 0/1 of channel 0, F012h and F013h the same requester pairs of channel 1, F002h target bytes 0/1 of channel 1, F003h count bytes 0/1 of channel 1.
- R3: Some bytes have direct addresses. Channel 0 target byte 2 is at F087h and byte 3 at F086h. Channel 1 target byte 2 is at F083h and byte 3 at F085h. Count byte 2 is at F098h for channel 0 and at F099h for channel 1.
- R4: Each rising edge of the read or write strobe at a shared address flips the pointer exactly once. Holding a strobe high adds no further flips. When both strobes rise in the same cycle, only the write takes effect.
- R5: A write to F00Ch or 000Ch clears the pointer to 0 whatever its data. It changes no channel register.
- R6: Accesses to direct addresses or to unmapped addresses leave the pointer unchanged.
- R7: A read at a shared address returns the byte that the pointer selected before the access flipped it.
- R8: A read of an unmapped address returns 00h. A write to an unmapped address changes nothing.
- R9: A write changes only its addressed byte. The new value is visible on the parallel outputs the cycle after the write strobe rises.
- R10: A read at a direct address returns the stored byte. The value is held on the read data output from the cycle after the strobe rises until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 16 | Host byte address |
| host_wdata | input | 8 | Host write data |
| host_rd | input | 1 | Read strobe, acted on at its rising edge |
| host_wr | input | 1 | Write strobe, acted on at its rising edge |
| host_rdata | output | 8 | Registered read data |
| req_addr | output | 2x32 | Requester address per channel |
| tgt_addr | output | 2x32 | Target address per channel |
| byte_cnt | output | 2x24 | Byte count per channel |

## Verification
The bench checks the pointer sequence across mixed reads and writes. A design that toggled only on writes would read the wrong half after a read. A design that toggled on direct addresses would desynchronise the next shared access. A write strobe held for several cycles is followed by a second write. A design that toggled per cycle would put the second byte in the wrong half. The clear command is issued in the middle of a pair at both of its addresses, and a design that also stored its data would corrupt a register. Finally, every address in F000h–F0FFh is read and written with computed data. This catches stray decodes, unmapped reads that return stale data, and upper count bytes placed at the wrong index.

// File: rtl/dcr_pkg.sv
`timescale 1ns/1ps
package dcr_pkg;
  typedef enum logic [1:0] {K_REQ = 2'd0, K_TGT = 2'd1, K_CNT = 2'd2, K_NONE = 2'd3} reg_kind_e;

  typedef struct packed {
    logic      hit;      // readable/writable channel byte
    logic      shared;   // byte chosen through the pointer
    logic      clr;      // pointer clear command (write only)
    logic      ch;       // channel number
    reg_kind_e kind;
    logic [1:0] bsel;    // direct byte, or base byte of a shared pair
  } dec_t;

  localparam logic [15:0] A_CLR_HI   = 16'hF00C;
  localparam logic [15:0] A_CLR_LO   = 16'h000C;
  localparam logic [15:0] A0_REQ_LO  = 16'hF010;
  localparam logic [15:0] A0_REQ_HI  = 16'hF011;
  localparam logic [15:0] A0_TGT_SH  = 16'hF000;
  localparam logic [15:0] A0_TGT_B2  = 16'hF087;
  localparam logic [15:0] A0_TGT_B3  = 16'hF086;
  localparam logic [15:0] A0_CNT_SH  = 16'hF001;
  localparam logic [15:0] A0_CNT_B2  = 16'hF098;
  localparam logic [15:0] A1_REQ_LO  = 16'hF012;
  localparam logic [15:0] A1_REQ_HI  = 16'hF013;
  localparam logic [15:0] A1_TGT_SH  = 16'hF002;
  localparam logic [15:0] A1_TGT_B2  = 16'hF083;
  localparam logic [15:0] A1_TGT_B3  = 16'hF085;
  localparam logic [15:0] A1_CNT_SH  = 16'hF003;
  localparam logic [15:0] A1_CNT_B2  = 16'hF099;

  function automatic dec_t mk(input logic sh, input logic ch, input reg_kind_e k,
                              input logic [1:0] b);
    dec_t d;
    d.hit = 1'b1; d.shared = sh; d.clr = 1'b0; d.ch = ch; d.kind = k; d.bsel = b;
    return d;
  endfunction
endpackage

// File: rtl/dcr_decode.sv
`timescale 1ns/1ps
module dcr_decode
  import dcr_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic [AW-1:0] addr,
  output dec_t          dec
);
  logic [15:0] a16;
  assign a16 = 16'(addr);

  always_comb begin
    dec = '{hit: 1'b0, shared: 1'b0, clr: 1'b0, ch: 1'b0, kind: K_NONE, bsel: 2'd0};
    case (a16)
      A_CLR_HI, A_CLR_LO: dec.clr = 1'b1;
      A0_REQ_LO: dec = mk(1'b1, 1'b0, K_REQ, 2'd0);
      A0_REQ_HI: dec = mk(1'b1, 1'b0, K_REQ, 2'd2);
      A0_TGT_SH: dec = mk(1'b1, 1'b0, K_TGT, 2'd0);
      A0_TGT_B2: dec = mk(1'b0, 1'b0, K_TGT, 2'd2);
      A0_TGT_B3: dec = mk(1'b0, 1'b0, K_TGT, 2'd3);
      A0_CNT_SH: dec = mk(1'b1, 1'b0, K_CNT, 2'd0);
      A0_CNT_B2: dec = mk(1'b0, 1'b0, K_CNT, 2'd2);
      A1_REQ_LO: dec = mk(1'b1, 1'b1, K_REQ, 2'd0);
      A1_REQ_HI: dec = mk(1'b1, 1'b1, K_REQ, 2'd2);
      A1_TGT_SH: dec = mk(1'b1, 1'b1, K_TGT, 2'd0);
      A1_TGT_B2: dec = mk(1'b0, 1'b1, K_TGT, 2'd2);
      A1_TGT_B3: dec = mk(1'b0, 1'b1, K_TGT, 2'd3);
      A1_CNT_SH: dec = mk(1'b1, 1'b1, K_CNT, 2'd0);
      A1_CNT_B2: dec = mk(1'b0, 1'b1, K_CNT, 2'd2);
      default: ;
    endcase
  end
endmodule

// File: rtl/dcr_byteptr.sv
`timescale 1ns/1ps
module dcr_byteptr (
  input  logic clk,
  input  logic rst,
  input  logic rd,
  input  logic wr,
  input  logic shared,
  input  logic clr,
  output logic rd_go,
  output logic wr_go,
  output logic bp
);
  logic rd_q, wr_q;

  // one access per strobe rising edge; write wins when both rise
  assign wr_go = wr & ~wr_q;
  assign rd_go = rd & ~rd_q & ~wr_go;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= 1'b0;
      wr_q <= 1'b0;
      bp   <= 1'b0;
    end else begin
      rd_q <= rd;
      wr_q <= wr;
      if (wr_go && clr)
        bp <= 1'b0;
      else if ((rd_go || wr_go) && shared)
        bp <= ~bp;
    end
  end
endmodule

// File: rtl/dcr_channel.sv
`timescale 1ns/1ps
module dcr_channel
  import dcr_pkg::*;
#(
  parameter int REQ_BITS = 32,
  parameter int TGT_BITS = 32,
  parameter int CNT_BITS = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  reg_kind_e           kind,
  input  logic [1:0]          bidx,
  input  logic [7:0]          wdata,
  output logic [REQ_BITS-1:0] req_o,
  output logic [TGT_BITS-1:0] tgt_o,
  output logic [CNT_BITS-1:0] cnt_o,
  output logic [7:0]          rd_byte
);
  localparam int RB = REQ_BITS / 8;
  localparam int TB = TGT_BITS / 8;
  localparam int CB = CNT_BITS / 8;

  logic [RB-1:0][7:0] req_q;
  logic [TB-1:0][7:0] tgt_q;
  logic [CB-1:0][7:0] cnt_q;

  for (genvar b = 0; b < RB; b++) begin : g_req
    always_ff @(posedge clk) begin
      if (rst) req_q[b] <= 8'h00;
      else if (wr_en && kind == K_REQ && bidx == 2'(b)) req_q[b] <= wdata;
    end
  end
  for (genvar b = 0; b < TB; b++) begin : g_tgt
    always_ff @(posedge clk) begin
      if (rst) tgt_q[b] <= 8'h00;
      else if (wr_en && kind == K_TGT && bidx == 2'(b)) tgt_q[b] <= wdata;
    end
  end
  for (genvar b = 0; b < CB; b++) begin : g_cnt
    always_ff @(posedge clk) begin
      if (rst) cnt_q[b] <= 8'h00;
      else if (wr_en && kind == K_CNT && bidx == 2'(b)) cnt_q[b] <= wdata;
    end
  end

  assign req_o = req_q;
  assign tgt_o = tgt_q;
  assign cnt_o = cnt_q;

  always_comb begin
    rd_byte = 8'h00;
    case (kind)
      K_REQ: if (int'(bidx) < RB) rd_byte = req_q[bidx];
      K_TGT: if (int'(bidx) < TB) rd_byte = tgt_q[bidx];
      K_CNT: if (int'(bidx) < CB) rd_byte = cnt_q[bidx];
      default: rd_byte = 8'h00;
    endcase
  end
endmodule

// File: rtl/dma_chreg_file.sv
`timescale 1ns/1ps
module dma_chreg_file
  import dcr_pkg::*;
#(
  parameter int AW       = 16,
  parameter int REQ_BITS = 32,
  parameter int TGT_BITS = 32,
  parameter int CNT_BITS = 24
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [AW-1:0]            host_addr,
  input  logic [7:0]               host_wdata,
  input  logic                     host_rd,
  input  logic                     host_wr,
  output logic [7:0]               host_rdata,
  output logic [1:0][REQ_BITS-1:0] req_addr,
  output logic [1:0][TGT_BITS-1:0] tgt_addr,
  output logic [1:0][CNT_BITS-1:0] byte_cnt
);
  localparam int NCH = 2;

  dec_t       dec;
  logic       rd_go, wr_go, bp_q;
  logic       dec_shared, dec_hit;
  logic [1:0] bidx;
  logic [NCH-1:0][7:0] ch_rd;

  dcr_decode #(.AW(AW)) u_dec (.addr(host_addr), .dec(dec));

  assign dec_shared = dec.hit & dec.shared;
  assign dec_hit    = dec.hit;

  dcr_byteptr u_bp (
    .clk(clk), .rst(rst), .rd(host_rd), .wr(host_wr),
    .shared(dec_shared), .clr(dec.clr),
    .rd_go(rd_go), .wr_go(wr_go), .bp(bp_q)
  );

  // pointer picks the half of a shared pair; direct bytes use their own index
  assign bidx = dec.shared ? {dec.bsel[1], bp_q} : dec.bsel;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    dcr_channel #(.REQ_BITS(REQ_BITS), .TGT_BITS(TGT_BITS), .CNT_BITS(CNT_BITS)) u_ch (
      .clk(clk), .rst(rst),
      .wr_en(wr_go && dec.hit && (dec.ch == 1'(c))),
      .kind(dec.kind), .bidx(bidx), .wdata(host_wdata),
      .req_o(req_addr[c]), .tgt_o(tgt_addr[c]), .cnt_o(byte_cnt[c]),
      .rd_byte(ch_rd[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= 8'h00;
    else if (rd_go)
      host_rdata <= dec.hit ? ch_rd[dec.ch] : 8'h00;
  end
endmodule

// File: rtl/dcr_checker.sv
`timescale 1ns/1ps
module dcr_checker #(
  parameter int AW       = 16,
  parameter int REQ_BITS = 32,
  parameter int TGT_BITS = 32,
  parameter int CNT_BITS = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic [AW-1:0]            host_addr,
  input logic                     host_rd,
  input logic                     host_wr,
  input logic [7:0]               host_rdata,
  input logic [1:0][REQ_BITS-1:0] req_addr,
  input logic [1:0][TGT_BITS-1:0] tgt_addr,
  input logic [1:0][CNT_BITS-1:0] byte_cnt,
  input logic                     bp,
  input logic                     dec_shared,
  input logic                     dec_hit
);
  logic rd_p, wr_p;
  logic wr_e, rd_e, clr_e;

  always_ff @(posedge clk) begin
    if (rst) begin rd_p <= 1'b0; wr_p <= 1'b0; end
    else begin rd_p <= host_rd; wr_p <= host_wr; end
  end

  assign wr_e  = host_wr & ~wr_p;
  assign rd_e  = host_rd & ~rd_p & ~wr_e;
  assign clr_e = wr_e && (16'(host_addr) == 16'hF00C || 16'(host_addr) == 16'h000C);

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (bp == 1'b0 && host_rdata == 8'h00 && req_addr == '0 && tgt_addr == '0 && byte_cnt == '0));

  // R4
  a_r4_shared_flips: assert property (@(posedge clk) disable iff (rst)
    ((wr_e || rd_e) && dec_shared) |=> (bp != $past(bp)));

  // R5
  a_r5_clear_zeroes: assert property (@(posedge clk) disable iff (rst)
    clr_e |=> (bp == 1'b0 && $stable(req_addr) && $stable(tgt_addr) && $stable(byte_cnt)));

  // R6
  a_r6_no_flip: assert property (@(posedge clk) disable iff (rst)
    (!((wr_e || rd_e) && dec_shared) && !clr_e) |=> $stable(bp));

  // R8
  a_r8_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_e && !dec_hit) |=> (host_rdata == 8'h00));

  // R9
  a_r9_write_only_on_edge: assert property (@(posedge clk) disable iff (rst)
    !(wr_e && dec_hit) |=> ($stable(req_addr) && $stable(tgt_addr) && $stable(byte_cnt)));

  // R10
  a_r10_rdata_held: assert property (@(posedge clk) disable iff (rst)
    !rd_e |=> $stable(host_rdata));
endmodule

bind dma_chreg_file dcr_checker #(
  .AW(AW), .REQ_BITS(REQ_BITS), .TGT_BITS(TGT_BITS), .CNT_BITS(CNT_BITS)
) u_chk (
  .clk(clk), .rst(rst), .host_addr(host_addr), .host_rd(host_rd), .host_wr(host_wr),
  .host_rdata(host_rdata), .req_addr(req_addr), .tgt_addr(tgt_addr), .byte_cnt(byte_cnt),
  .bp(bp_q), .dec_shared(dec_shared), .dec_hit(dec_hit)
);

// File: tb/dma_chreg_file_tb_top.sv
`timescale 1ns/1ps
module dma_chreg_file_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic host_rd = 1'b0, host_wr = 1'b0;
  logic [7:0]  host_rdata;
  logic [1:0][31:0] req_addr, tgt_addr;
  logic [1:0][23:0] byte_cnt;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  logic [7:0] m [2][3][4];
  bit mbp;

  always #4 clk = ~clk;

  dma_chreg_file dut_i (
    .clk(clk), .rst(rst), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rd(host_rd), .host_wr(host_wr), .host_rdata(host_rdata),
    .req_addr(req_addr), .tgt_addr(tgt_addr), .byte_cnt(byte_cnt)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  // address map from R2/R3
  function automatic void bdec(input logic [15:0] a, output bit mp, output bit sh,
                               output int ch, output int k, output int b);
    mp = 1; sh = 0; ch = 0; k = 0; b = 0;
    case (a)
      16'hF010: begin sh = 1; k = 0; b = 0; end
      16'hF011: begin sh = 1; k = 0; b = 2; end
      16'hF000: begin sh = 1; k = 1; b = 0; end
      16'hF087: begin k = 1; b = 2; end
      16'hF086: begin k = 1; b = 3; end
      16'hF001: begin sh = 1; k = 2; b = 0; end
      16'hF098: begin k = 2; b = 2; end
      16'hF012: begin ch = 1; sh = 1; k = 0; b = 0; end
      16'hF013: begin ch = 1; sh = 1; k = 0; b = 2; end
      16'hF002: begin ch = 1; sh = 1; k = 1; b = 0; end
      16'hF083: begin ch = 1; k = 1; b = 2; end
      16'hF085: begin ch = 1; k = 1; b = 3; end
      16'hF003: begin ch = 1; sh = 1; k = 2; b = 0; end
      16'hF099: begin ch = 1; k = 2; b = 2; end
      default: mp = 0;
    endcase
  endfunction

  task automatic check_outs(input string r);
    for (int c = 0; c < 2; c++) begin
      chk(req_addr[c] == {m[c][0][3], m[c][0][2], m[c][0][1], m[c][0][0]}, r,
          req_addr[c], {m[c][0][3], m[c][0][2], m[c][0][1], m[c][0][0]});
      chk(tgt_addr[c] == {m[c][1][3], m[c][1][2], m[c][1][1], m[c][1][0]}, r,
          tgt_addr[c], {m[c][1][3], m[c][1][2], m[c][1][1], m[c][1][0]});
      chk(byte_cnt[c] == {m[c][2][2], m[c][2][1], m[c][2][0]}, r,
          {8'h00, byte_cnt[c]}, {8'h00, m[c][2][2], m[c][2][1], m[c][2][0]});
    end
  endtask

  // one access: strobe rises at a negedge, held for 'hold' cycles, sampled when it drops
  task automatic access(input logic [15:0] a, input bit is_wr, input logic [7:0] d,
                        input int hold, input string r);
    bit mp, sh; int ch, k, b, idx;
    logic [7:0] exp;
    bdec(a, mp, sh, ch, k, b);
    idx = sh ? (b + int'(mbp)) : b;
    exp = 8'h00;
    if (is_wr) begin
      if (a == 16'hF00C || a == 16'h000C) mbp = 0;
      else if (mp) begin
        if (k != 2 || idx < 3) m[ch][k][idx] = d;
        if (sh) mbp = ~mbp;
      end
    end else begin
      if (mp) begin
        exp = (k == 2 && idx > 2) ? 8'h00 : m[ch][k][idx];
        if (sh) mbp = ~mbp;
      end
    end
    @(negedge clk);
    host_addr = a; host_wdata = d;
    if (is_wr) host_wr = 1'b1; else host_rd = 1'b1;
    repeat (hold) @(negedge clk);
    host_wr = 1'b0; host_rd = 1'b0;
    if (!is_wr) chk(host_rdata == exp, r, {24'h0, host_rdata}, {24'h0, exp});
    check_outs(r);
  endtask

  initial begin
    for (int c = 0; c < 2; c++) for (int k = 0; k < 3; k++) for (int b = 0; b < 4; b++) m[c][k][b] = 8'h00;
    mbp = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk(host_rdata == 8'h00, "R1", {24'h0, host_rdata}, 32'h0);
    check_outs("R1");

    // R2/R3/R9: program every byte of both channels
    access(16'hF00C, 1, 8'hA5, 1, "R5");
    access(16'hF010, 1, 8'h11, 1, "R2"); access(16'hF010, 1, 8'h22, 1, "R2");
    access(16'hF011, 1, 8'h33, 1, "R2"); access(16'hF011, 1, 8'h44, 1, "R2");
    access(16'hF000, 1, 8'h55, 1, "R2"); access(16'hF000, 1, 8'h66, 1, "R2");
    access(16'hF087, 1, 8'h77, 1, "R3"); access(16'hF086, 1, 8'h88, 1, "R3");
    access(16'hF001, 1, 8'h99, 1, "R2"); access(16'hF001, 1, 8'hAA, 1, "R2");
    access(16'hF098, 1, 8'hBB, 1, "R3");
    access(16'hF012, 1, 8'hC1, 1, "R2"); access(16'hF012, 1, 8'hC2, 1, "R2");
    access(16'hF013, 1, 8'hC3, 1, "R2"); access(16'hF013, 1, 8'hC4, 1, "R2");
    access(16'hF002, 1, 8'hD1, 1, "R2"); access(16'hF002, 1, 8'hD2, 1, "R2");
    access(16'hF083, 1, 8'hD3, 1, "R3"); access(16'hF085, 1, 8'hD4, 1, "R3");
    access(16'hF003, 1, 8'hE1, 1, "R2"); access(16'hF003, 1, 8'hE2, 1, "R2");
    access(16'hF099, 1, 8'hE3, 1, "R3");
    chk(req_addr[0] == 32'h44332211, "R2", req_addr[0], 32'h44332211);
    chk(tgt_addr[1] == 32'hD4D3D2D1, "R3", tgt_addr[1], 32'hD4D3D2D1);
    chk(byte_cnt[0] == 24'hBBAA99, "R3", {8'h0, byte_cnt[0]}, 32'h00BBAA99);

    // R7/R10: read back through shared and direct addresses
    access(16'hF010, 0, 8'h00, 1, "R7"); access(16'hF010, 0, 8'h00, 1, "R7");
    access(16'hF087, 0, 8'h00, 1, "R10"); access(16'hF099, 0, 8'h00, 1, "R10");
    access(16'hF003, 0, 8'h00, 1, "R7"); access(16'hF003, 0, 8'h00, 1, "R7");

    // R6: direct access between halves keeps pointer
    access(16'hF002, 0, 8'h00, 1, "R6");
    access(16'hF085, 1, 8'h5A, 1, "R6");
    access(16'h1234, 1, 8'hFF, 1, "R6");
    access(16'hF002, 0, 8'h00, 1, "R6");

    // R4: held write strobe counts once, and a read after write sees the next half
    access(16'hF000, 1, 8'h01, 5, "R4");
    access(16'hF000, 1, 8'h02, 3, "R4");
    access(16'hF000, 1, 8'h03, 1, "R4");
    access(16'hF000, 0, 8'h00, 4, "R4");

    // R5: clear in the middle of a pair, both addresses
    access(16'hF012, 1, 8'h7E, 1, "R5");
    access(16'h000C, 1, 8'hFF, 1, "R5");
    access(16'hF012, 1, 8'h7F, 1, "R5");
    chk(req_addr[1][15:0] == 16'hC27F, "R5", {16'h0, req_addr[1][15:0]}, 32'h0000C27F);
    access(16'hF00C, 1, 8'h00, 1, "R5");
    access(16'hF00C, 0, 8'h00, 1, "R8");

    // R4: both strobes rising together act as the write only
    @(negedge clk);
    host_addr = 16'hF001; host_wdata = 8'h6C; host_rd = 1'b1; host_wr = 1'b1;
    m[0][2][0] = 8'h6C; mbp = 1;
    @(negedge clk); host_rd = 1'b0; host_wr = 1'b0;
    check_outs("R4");
    access(16'hF001, 0, 8'h00, 1, "R4");

    // R8/R2/R3: sweep every address of the page, reads then writes
    for (int i = 0; i < 256; i++) access(16'hF000 | 16'(i), 0, 8'h00, 1, "R8");
    for (int i = 0; i < 256; i++) access(16'hF000 | 16'(i), 1, 8'(i * 37 + 11), 1, "R9");
    for (int i = 0; i < 16; i++) access(16'(i), 1, 8'(i * 13), 1, "R8");
    for (int i = 0; i < 256; i++) access(16'hF000 | 16'(i), 0, 8'h00, 1, "R7");

    // R1: reset again after traffic
    @(negedge clk); rst = 1'b1; @(negedge clk); rst = 1'b0;
    for (int c = 0; c < 2; c++) for (int k = 0; k < 3; k++) for (int b = 0; b < 4; b++) m[c][k][b] = 8'h00;
    mbp = 0;
    chk(host_rdata == 8'h00, "R1", {24'h0, host_rdata}, 32'h0);
    check_outs("R1");
    access(16'hF011, 0, 8'h00, 1, "R1");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule